// File: doc/BRIEF.md
# Mode-Selectable SPI Byte Master

This block is a full-duplex SPI master that moves one byte per transfer. An upstream stage offers bytes on a valid/ready stream. For each accepted byte the block produces sixteen serial clock edges. It shifts the byte out most significant bit first and captures a byte from the slave at the same time. That captured byte is returned on an output stream as a one-cycle strobe with its data. No escaping or framing is applied.

The clock polarity and the capture edge come from a 2-bit mode input. The bit rate comes from a 3-bit code that selects one of eight dividers, each derived from the system clock frequency parameter. Both inputs are sampled when a byte is accepted, so the upstream command decoder can change them between bytes. While no byte is in flight, the serial clock tracks the idle level of the current mode.

A bank of active-low chip-select lines is driven by the block. Accepting a byte pulls the selected line low. A line returns high only on an explicit release command.

Top module: `spi_byte_master`

## Requirements
- R1: `tx_ready_o` is high exactly when no byte is in flight. A byte is accepted on a rising clock edge with `tx_valid_i` and `tx_ready_o` both high. `tx_ready_o` then stays low until the transfer ends. `rx_valid_o` pulses for one cycle, and `tx_ready_o` rises in the same cycle, 16·H clock cycles after the accepting edge.
- R2: Each byte produces exactly 16 serial clock edges (8 cycles), each half period lasting H system clocks. H = max(1, floor(CLK_HZ / (2·bps))). The `rate_i` codes 0..7 select bps = 10_400_000, 2_600_000, 650_000, 100_000, 50_000, 10_000, 5_000, 1_300.
- R3: Transmitted data leaves on `mosi_o` most significant bit first.
- R4: The `mode_i` value selects the idle clock level and the capture edge. Mode 0 idles low and captures on rising edges. Mode 1 idles low and captures on falling edges. Mode 2 idles high and captures on falling edges. Mode 3 idles high and captures on rising edges. In modes 0 and 2, data changes on the non-capture edges and the first bit is valid before the first edge. In modes 1 and 3, data changes on non-capture edges after the first one.
- R5: The byte sampled from `miso_i` on the 8 capture edges, first sample as the most significant bit, appears unmodified on `rx_data_o` while `rx_valid_o` is high.
- R6: `mode_i` and `rate_i` are sampled on the accepting edge. Changing them while a byte is in flight has no effect on that byte's data or duration.
- R7: While idle, `sclk_o` equals the idle level (bit 1) of the `mode_i` value seen one cycle earlier.
- R8: On acceptance, `cs_n_o[cs_sel_i]` is driven low and the other lines keep their state. The selected line stays low for the whole byte and afterwards.
- R9: `cs_release_i` drives all of `cs_n_o` high on the next cycle when the block is idle and no byte is being accepted. While a byte is in flight it has no effect.
- R10: After reset, `tx_ready_o`=1, `rx_valid_o`=0, `sclk_o`=0, `mosi_o`=0 and all of `cs_n_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Clock mode for the next byte |
| rate_i | input | 3 | Bit-rate code for the next byte |
| tx_valid_i | input | 1 | Byte offered for transmission |
| tx_data_i | input | 8 | Byte to transmit |
| tx_ready_o | output | 1 | Block can accept a byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| cs_sel_i | input | $clog2(NUM_CS) | Chip-select line lowered by the next byte |
| cs_release_i | input | 1 | Raise all chip-select lines |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slave |
| miso_i | input | 1 | Serial data from slave |
| cs_n_o | output | NUM_CS | Active-low chip-select lines |

## Verification
The idle-level assertion assumes that reset released with the block idle, so the previous cycle's mode is meaningful. The chip-select checks assume that `cs_sel_i` names an existing line. The stimulus keeps `cs_sel_i` within the line count. It also lets the mode settle for a few cycles before each byte, so the bench slave model never counts a clock edge from an idle-level change as part of a transfer. Mid-byte changes of mode, rate and release are injected only in a directed case. That case tests that these inputs are ignored.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  typedef enum logic {ST_IDLE, ST_SHIFT} st_e;

  function automatic int unsigned rate_bps(input int unsigned idx);
    case (idx)
      0: return 10_400_000;
      1: return 2_600_000;
      2: return 650_000;
      3: return 100_000;
      4: return 50_000;
      5: return 10_000;
      6: return 5_000;
      default: return 1_300;
    endcase
  endfunction

  // system clocks per serial half period, never below one
  function automatic int unsigned half_cycles(input int unsigned clk_hz, input int unsigned idx);
    int unsigned h;
    h = clk_hz / (2 * rate_bps(idx));
    return (h == 0) ? 1 : h;
  endfunction

endpackage

// File: rtl/spi_bm_clkgen.sv
module spi_bm_clkgen #(
  parameter int unsigned CLK_HZ = 250_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned NRATE    = 8;
  localparam int unsigned MAX_HALF = spi_bm_pkg::half_cycles(CLK_HZ, NRATE - 1);
  localparam int unsigned CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] half_tbl [NRATE];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic [2:0]    rate_q;

  for (genvar gi = 0; gi < NRATE; gi++) begin : g_tbl
    assign half_tbl[gi] = CW'(spi_bm_pkg::half_cycles(CLK_HZ, gi));
  end

  assign lim    = half_tbl[rate_q] - CW'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (start_i) rate_q <= rate_i;
      if (!run_i || tick_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + CW'(1);
    end
  end

  // R6
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !start_i |=> $stable(rate_q) || !run_i);

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
  import spi_bm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_ready_o,
  output logic       start_o,
  input  logic       tick_i,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o
);
  st_e        st_q;
  logic [1:0] mode_q;
  logic       sclk_q;
  logic [7:0] tx_sh_q;
  logic [7:0] rx_sh_q;
  logic [3:0] edge_q;
  logic       rx_vld_q;
  logic       lead;
  logic       samp;
  logic       past_ok_q;

  assign tx_ready_o = (st_q == ST_IDLE);
  assign start_o    = tx_ready_o && tx_valid_i;
  assign lead       = (sclk_q == mode_q[1]);   // clock leaving idle level
  assign samp       = lead ^ mode_q[0];
  assign sclk_o     = sclk_q;
  assign mosi_o     = tx_sh_q[7];
  assign rx_valid_o = rx_vld_q;
  assign rx_data_o  = rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mode_q   <= '0;
      sclk_q   <= 1'b0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      edge_q   <= '0;
      rx_vld_q <= 1'b0;
    end else begin
      rx_vld_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        mode_q <= mode_i;
        sclk_q <= mode_i[1];
        if (tx_valid_i) begin
          st_q    <= ST_SHIFT;
          tx_sh_q <= tx_data_i;
          edge_q  <= '0;
        end
      end else if (tick_i) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 4'd1;
        if (samp) rx_sh_q <= {rx_sh_q[6:0], miso_i};
        else if (!(mode_q[0] && edge_q == 4'd0)) tx_sh_q <= {tx_sh_q[6:0], 1'b0};
        if (edge_q == 4'd15) begin
          st_q     <= ST_IDLE;
          rx_vld_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  // R1
  accept_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !tx_ready_o);

  // R1
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> tx_ready_o ##1 !rx_valid_o);

  // R7
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && tx_ready_o && $past(tx_ready_o) |-> sclk_o == $past(mode_i[1]));

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_o && !rx_valid_o |=> $stable(mode_q) || tx_ready_o);

endmodule

// File: rtl/spi_bm_cs.sv
module spi_bm_cs #(
  parameter int unsigned NUM_CS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      idle_i,
  input  logic [$clog2(NUM_CS)-1:0] sel_i,
  input  logic                      release_i,
  output logic [NUM_CS-1:0]         cs_n_o
);
  localparam int unsigned SW = $clog2(NUM_CS);

  logic [NUM_CS-1:0] cs_n_q;
  logic [SW-1:0]     sel_q;
  logic              past_ok_q;

  assign cs_n_o = cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q <= '1;
      sel_q  <= '0;
    end else if (start_i) begin
      cs_n_q[sel_i] <= 1'b0;
      sel_q         <= sel_i;
    end else if (release_i && idle_i) begin
      cs_n_q <= '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  // R8
  sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !idle_i && (32'(sel_q) < NUM_CS) |-> !cs_n_o[sel_q]);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !idle_i && $past(!idle_i) |-> $stable(cs_n_o));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int unsigned NUM_CS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                mode_i,
  input  logic [2:0]                rate_i,
  input  logic                      tx_valid_i,
  input  logic [7:0]                tx_data_i,
  output logic                      tx_ready_o,
  output logic                      rx_valid_o,
  output logic [7:0]                rx_data_o,
  input  logic [$clog2(NUM_CS)-1:0] cs_sel_i,
  input  logic                      cs_release_i,
  output logic                      sclk_o,
  output logic                      mosi_o,
  input  logic                      miso_i,
  output logic [NUM_CS-1:0]         cs_n_o
);
  logic start;
  logic tick;

  spi_bm_clkgen #(.CLK_HZ(CLK_HZ)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (!tx_ready_o),
    .rate_i  (rate_i),
    .tick_o  (tick)
  );

  spi_bm_shifter u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .tx_ready_o (tx_ready_o),
    .start_o    (start),
    .tick_i     (tick),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .miso_i     (miso_i),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o)
  );

  spi_bm_cs #(.NUM_CS(NUM_CS)) u_cs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .idle_i    (tx_ready_o),
    .sel_i     (cs_sel_i),
    .release_i (cs_release_i),
    .cs_n_o    (cs_n_o)
  );

endmodule

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  localparam int unsigned CLK_HZ = 5_200_000;
  localparam int unsigned NUM_CS = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic [2:0] rate_i = '0;
  logic       tx_valid_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_ready_o;
  logic       rx_valid_o;
  logic [7:0] rx_data_o;
  logic [1:0] cs_sel_i = '0;
  logic       cs_release_i = 1'b0;
  logic       sclk_o;
  logic       mosi_o;
  logic       miso_i;
  logic [NUM_CS-1:0] cs_n_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [NUM_CS-1:0] exp_cs = '1;

  // slave model state
  logic [7:0] s_tx = '0;
  logic [7:0] s_rx = '0;
  int         s_edges = 16;
  logic [1:0] s_mode = '0;
  logic [7:0] arm_tx = '0;
  logic [1:0] arm_mode = '0;
  bit         arm_tok = 1'b0;
  bit         arm_seen = 1'b0;

  always #2 clk = ~clk;

  spi_byte_master #(.CLK_HZ(CLK_HZ), .NUM_CS(NUM_CS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .rate_i(rate_i),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .cs_sel_i(cs_sel_i),
    .cs_release_i(cs_release_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  assign miso_i = s_tx[7];

  // SPI slave per R4: capture on the mode's capture edge, shift on the others
  initial begin
    forever begin
      @(sclk_o or arm_tok);
      if (arm_tok != arm_seen) begin
        arm_seen = arm_tok;
        s_tx = arm_tx; s_rx = '0; s_edges = 0; s_mode = arm_mode;
      end else if (s_edges < 16) begin
        if ((sclk_o != s_mode[1]) ^ s_mode[0]) s_rx = {s_rx[6:0], mosi_o};
        else if (!(s_mode[0] && s_edges == 0)) s_tx = {s_tx[6:0], 1'b0};
        s_edges++;
      end
    end
  end

  function automatic int exp_half(input int r);
    int bps;
    int h;
    case (r)
      0: bps = 10_400_000; 1: bps = 2_600_000; 2: bps = 650_000; 3: bps = 100_000;
      4: bps = 50_000; 5: bps = 10_000; 6: bps = 5_000; default: bps = 1_300;
    endcase
    h = CLK_HZ / (2 * bps);
    return (h == 0) ? 1 : h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, input logic [1:0] m, input logic [2:0] r,
                      input logic [1:0] sel, input logic [7:0] sbyte, input bit disturb);
    int n;
    @(negedge clk); mode_i = m; rate_i = r;
    repeat (3) @(negedge clk);
    chk(sclk_o == m[1], "R7 idle level", sclk_o, m[1]);
    arm_tx = sbyte; arm_mode = m; arm_tok = ~arm_tok;
    tx_valid_i = 1'b1; tx_data_i = d; cs_sel_i = sel;
    chk(tx_ready_o == 1'b1, "R1 ready idle", tx_ready_o, 1);
    @(posedge clk);
    exp_cs[sel] = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        tx_valid_i = 1'b0;
        chk(tx_ready_o == 1'b0, "R1 stall", tx_ready_o, 0);
        chk(cs_n_o[sel] == 1'b0, "R8 cs low", cs_n_o[sel], 0);
      end
      if (disturb && n == 2) begin
        mode_i = ~m; rate_i = r ^ 3'd1; cs_release_i = 1'b1;
      end
      if (disturb && n == 3) cs_release_i = 1'b0;
    end while (!rx_valid_o && n < 40000);
    chk(n == 16 * exp_half(r) + 1, disturb ? "R6 duration" : "R1 latency", n, 16 * exp_half(r) + 1);
    chk(s_edges == 16, "R2 edge count", s_edges, 16);
    chk(s_rx == d, disturb ? "R6 R3 mosi" : "R3 R4 mosi", s_rx, d);
    chk(rx_data_o == sbyte, "R5 R4 rx data", rx_data_o, sbyte);
    chk(tx_ready_o == 1'b1, "R1 ready back", tx_ready_o, 1);
    chk(cs_n_o == exp_cs, disturb ? "R9 release ignored" : "R8 cs state", cs_n_o, exp_cs);
    @(negedge clk);
    chk(rx_valid_o == 1'b0, "R1 pulse width", rx_valid_o, 0);
  endtask

  task automatic release_cs();
    @(negedge clk); cs_release_i = 1'b1;
    @(negedge clk); cs_release_i = 1'b0;
    exp_cs = '1;
    chk(cs_n_o == exp_cs, "R9 release", cs_n_o, exp_cs);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R10
    chk(tx_ready_o == 1'b1, "R10 ready", tx_ready_o, 1);
    chk(rx_valid_o == 1'b0, "R10 rx_valid", rx_valid_o, 0);
    chk(sclk_o == 1'b0, "R10 sclk", sclk_o, 0);
    chk(mosi_o == 1'b0, "R10 mosi", mosi_o, 0);
    chk(cs_n_o == '1, "R10 cs", cs_n_o, 4'hF);
    rst_ni = 1'b1;

    // R4 every mode at the fastest rate
    xfer(8'hA5, 2'd0, 3'd0, 2'd0, 8'h3C, 1'b0);
    xfer(8'h81, 2'd1, 3'd0, 2'd0, 8'h7E, 1'b0);
    xfer(8'h01, 2'd2, 3'd1, 2'd1, 8'h80, 1'b0);
    xfer(8'hFE, 2'd3, 3'd2, 2'd2, 8'h55, 1'b0);
    release_cs();
    // R2 slow rates
    xfer(8'h5A, 2'd1, 3'd5, 2'd3, 8'hC3, 1'b0);
    xfer(8'h96, 2'd2, 3'd6, 2'd3, 8'h0F, 1'b0);
    xfer(8'h69, 2'd3, 3'd7, 2'd0, 8'hF0, 1'b0);
    // R6 R9 inputs changed mid-byte
    xfer(8'hC7, 2'd0, 3'd3, 2'd1, 8'h2D, 1'b1);
    release_cs();

    for (int i = 0; i < 40; i++) begin
      xfer(8'($urandom), 2'($urandom), 3'($urandom_range(0, 4)), 2'($urandom),
           8'($urandom), 1'b0);
      if ($urandom_range(0, 3) == 0) release_cs();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule